// File: doc/BRIEF.md
# Chip Reset and Start-up Sequencer

This block turns an asynchronous, active-low board reset into the reset and start-up timing that the rest of the chip and an attached line-interface PHY need. The PHY reset drops the moment the board reset falls, with no clock required. It then stays low for a fixed number of system clocks and releases by itself, even if the board reset is still low. The chip's own reset takes effect only at the first clock edge that sees the board reset low. It is released through a two-stage synchroniser, so deassertion is always clean with respect to the system clock.

Once the chip reset is released, the block runs a fixed start-up sequence. First comes a short command lockout window. Then comes a control-memory clearing phase, in which an address counter walks the whole memory one word per clock with a write strobe. When the counter wraps, a done flag rises, and from then on commands may be accepted. An error request from the core reaches the open-drain error pin only outside reset. During reset the pin is released to high impedance. The transmit clock is passed straight through and never stops for reset.

Top module: `reset_sequencer`

## Requirements
- R1: The chip reset output `core_rst_n` goes low at the first rising clock edge at which `rst_n_in` is low, and not earlier.
- R2: After `rst_n_in` rises, `core_rst_n` stays low through the first rising edge and goes high at the second rising edge.
- R3: `phy_rst_n` goes low combinationally, without a clock edge, when `rst_n_in` falls after having been sampled high.
- R4: `phy_rst_n` remains low through the 16th rising edge after the fall of `rst_n_in` and goes high at the 17th (PHY_HOLD = 17), whether or not `rst_n_in` is still low; it does not fall again until the next fall of `rst_n_in`.
- R5: An early rise of `rst_n_in` does not shorten the PHY reset pulse, and a new fall during the pulse restarts the 17-edge count.
- R6: `serr_oe` (1 = pull the open-drain error pin low) equals `serr_req` while `core_rst_n` is high and is 0 while `core_rst_n` is low.
- R7: `tx_clk_o` follows `tx_clk_i` at all times, including during reset.
- R8: Counting the edge at which `core_rst_n` rises as edge 0, `lock_busy` is high after edges 0 through 19 and low after edge 20; `init_busy` and `init_done` are low during the lockout.
- R9: `init_busy` and `init_we` are high after edges 20 through 20+32767, and `init_addr` reads 0 after edge 20 and increases by exactly one per clock up to 32767.
- R10: `init_done` rises after edge 20+32768, when the address wraps to 0, and stays high until the next reset; at most one of `lock_busy`, `init_busy` and `init_done` is high at a time.
- R11: A reset during the memory clearing phase drives `lock_busy`, `init_busy` and `init_done` low at the first edge and restarts the full sequence from the lockout on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n_in | input | 1 | Board reset, active low, asynchronous |
| tx_clk_i | input | 1 | Transmit clock source |
| serr_req | input | 1 | Core request to signal a system error |
| tx_clk_o | output | 1 | Transmit clock, free running through reset |
| core_rst_n | output | 1 | Synchronised chip reset, active low |
| phy_rst_n | output | 1 | PHY reset pulse, active low |
| serr_oe | output | 1 | Drive-low enable for the open-drain error pin |
| lock_busy | output | 1 | Command lockout window active |
| init_busy | output | 1 | Control-memory clearing in progress |
| init_we | output | 1 | Control-memory clear write strobe |
| init_addr | output | INIT_AW | Control-memory clear address |
| init_done | output | 1 | Start-up complete, commands may be issued |

## Verification
The bench samples the PHY reset between the board-reset fall and the next edge. A design that waited for a clock would leave the PHY running there. It then counts the pulse edge by edge, so an off-by-one counter shows up as a release one cycle early or late. A pulse tied to the board-reset level shows up as a missing release while the board reset is held. It also rises the board reset early and re-falls it mid-pulse, which catches a pulse that is cut short or not restarted. The lockout and clearing boundaries are checked on the exact edge, along with address stepping and the wrap into done. A reset in the middle of clearing must restart from the lockout, not resume or jump to done.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int PHY_HOLD    = 17,
  parameter int LOCK_CYCLES = 20,
  parameter int INIT_AW     = 15
) (
  input  logic               clk,
  input  logic               rst_n_in,
  input  logic               tx_clk_i,
  input  logic               serr_req,
  output logic               tx_clk_o,
  output logic               core_rst_n,
  output logic               phy_rst_n,
  output logic               serr_oe,
  output logic               lock_busy,
  output logic               init_busy,
  output logic               init_we,
  output logic [INIT_AW-1:0] init_addr,
  output logic               init_done
);

  localparam int PW = $clog2(PHY_HOLD + 1);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [INIT_AW-1:0] INIT_LAST = {INIT_AW{1'b1}};
  localparam logic [PW-1:0] PHY_LOAD = PW'(PHY_HOLD - 1);
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYCLES - 1);

  typedef enum logic [1:0] {S_LOCK, S_INIT, S_READY} seq_t;

  logic sync1, sync2;
  always_ff @(posedge clk) begin
    sync1 <= rst_n_in;
    sync2 <= rst_n_in & sync1;
  end
  assign core_rst_n = sync2;

  logic          last_hi;
  logic [PW-1:0] phy_cnt;
  logic          fall_now;
  assign fall_now = !rst_n_in && last_hi;

  always_ff @(posedge clk) begin
    last_hi <= rst_n_in;
    if (fall_now)
      phy_cnt <= PHY_LOAD;
    else if (phy_cnt != '0)
      phy_cnt <= phy_cnt - 1'b1;
  end
  assign phy_rst_n = !(fall_now || (phy_cnt != '0));

  seq_t               st;
  logic [LW-1:0]      lock_cnt;
  logic [INIT_AW-1:0] addr;
  logic               hold;
  assign hold = !rst_n_in || !sync2;

  always_ff @(posedge clk) begin
    if (hold) begin
      st       <= S_LOCK;
      lock_cnt <= '0;
      addr     <= '0;
    end else begin
      case (st)
        S_LOCK:
          if (lock_cnt == LOCK_LAST) st <= S_INIT;
          else lock_cnt <= lock_cnt + 1'b1;
        S_INIT: begin
          addr <= addr + 1'b1;
          if (addr == INIT_LAST) st <= S_READY;
        end
        default: st <= S_READY;
      endcase
    end
  end

  assign lock_busy = core_rst_n && (st == S_LOCK);
  assign init_busy = core_rst_n && (st == S_INIT);
  assign init_done = core_rst_n && (st == S_READY);
  assign init_we   = init_busy;
  assign init_addr = addr;
  assign serr_oe   = core_rst_n && serr_req;
  assign tx_clk_o  = tx_clk_i;

  logic        armed = 1'b0;
  logic [31:0] phy_low_run = '0;
  logic [31:0] lock_run = '0;
  always_ff @(posedge clk) begin
    armed       <= armed | !rst_n_in;
    phy_low_run <= phy_rst_n ? 32'd0 : phy_low_run + 32'd1;
    lock_run    <= lock_busy ? lock_run + 32'd1 : 32'd0;
  end

  p_serr_quiet_r6: assert property (@(posedge clk) disable iff (!armed)
    !rst_n_in |=> !serr_oe);

  p_phy_width_r4: assert property (@(posedge clk) disable iff (!armed)
    $rose(phy_rst_n) |-> (phy_low_run >= 32'(PHY_HOLD)));

  p_lock_len_r8: assert property (@(posedge clk) disable iff (!armed || !core_rst_n)
    $fell(lock_busy) |-> (lock_run == 32'(LOCK_CYCLES)));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!armed || !core_rst_n)
    (init_busy && $past(init_busy)) |-> (init_addr == $past(init_addr) + 1'b1));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!armed || !core_rst_n)
    $past(init_done) |-> init_done);

  p_one_phase_r10: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({lock_busy, init_busy, init_done}));

endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NV = 9;
  localparam logic [49:0] VECS [0:NV-1] = '{
    {32'd0,     1'b1, 1'b0, 1'b0, 15'd0},
    {32'd19,    1'b1, 1'b0, 1'b0, 15'd0},
    {32'd20,    1'b0, 1'b1, 1'b0, 15'd0},
    {32'd21,    1'b0, 1'b1, 1'b0, 15'd1},
    {32'd100,   1'b0, 1'b1, 1'b0, 15'd80},
    {32'd32786, 1'b0, 1'b1, 1'b0, 15'd32766},
    {32'd32787, 1'b0, 1'b1, 1'b0, 15'd32767},
    {32'd32788, 1'b0, 1'b0, 1'b1, 15'd0},
    {32'd32800, 1'b0, 1'b0, 1'b1, 15'd0}
  };

  logic clk = 1'b0, rst_n_in = 1'b1, tx_clk_i = 1'b0, serr_req = 1'b1;
  logic tx_clk_o, core_rst_n, phy_rst_n, serr_oe, lock_busy, init_busy, init_we, init_done;
  logic [14:0] init_addr;
  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  reset_sequencer uut (
    .clk(clk), .rst_n_in(rst_n_in), .tx_clk_i(tx_clk_i), .serr_req(serr_req),
    .tx_clk_o(tx_clk_o), .core_rst_n(core_rst_n), .phy_rst_n(phy_rst_n),
    .serr_oe(serr_oe), .lock_busy(lock_busy), .init_busy(init_busy),
    .init_we(init_we), .init_addr(init_addr), .init_done(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7 tx_clk_i = ~tx_clk_i;

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_to_edge0();
    rst_n_in = 1'b1;
    tick(1);
    chk("R2 still low after first edge", {31'd0, core_rst_n}, 0);
    tick(1);
    chk("R2 high after second edge", {31'd0, core_rst_n}, 1);
  endtask

  initial begin
    int bad_step;
    tick(3);
    // R3: fall between edges
    rst_n_in = 1'b0;
    #1;
    chk("R3 phy low before edge", {31'd0, phy_rst_n}, 0);
    chk("R1 core not low before edge", {31'd0, core_rst_n}, 1);
    tick(1);
    chk("R1 core low at first edge", {31'd0, core_rst_n}, 0);
    chk("R6 serr released in reset", {31'd0, serr_oe}, 0);
    chk("R7 tx clock in reset", {31'd0, tx_clk_o}, {31'd0, tx_clk_i});
    chk("R8 no status in reset", {29'd0, lock_busy, init_busy, init_done}, 0);
    tick(15);
    chk("R4 phy low after edge 16", {31'd0, phy_rst_n}, 0);
    tick(1);
    chk("R4 phy high after edge 17 with reset held", {31'd0, phy_rst_n}, 1);
    tick(5);
    chk("R4 phy stays high while reset held", {31'd0, phy_rst_n}, 1);
    chk("R1 core held low", {31'd0, core_rst_n}, 0);

    // main table walk
    release_to_edge0();
    chk("R6 serr follows request", {31'd0, serr_oe}, 1);
    serr_req = 1'b0;
    #1;
    chk("R6 serr off without request", {31'd0, serr_oe}, 0);
    chk("R7 tx clock after reset", {31'd0, tx_clk_o}, {31'd0, tx_clk_i});
    bad_step = 0;
    for (int k = 0; k <= 32800; k++) begin
      for (int v = 0; v < NV; v++) begin
        if (VECS[v][49:18] == 32'(k)) begin
          chk("R8 lock_busy vector", {31'd0, lock_busy}, {31'd0, VECS[v][17]});
          chk("R9 init_busy vector", {31'd0, init_busy}, {31'd0, VECS[v][16]});
          chk("R10 init_done vector", {31'd0, init_done}, {31'd0, VECS[v][15]});
          chk("R9 init_addr vector", {17'd0, init_addr}, {17'd0, VECS[v][14:0]});
        end
      end
      if (k >= 20 && k < 32788)
        if (init_addr !== 15'(k - 20) || init_we !== 1'b1) bad_step++;
      if (k < 20 && init_we !== 1'b0) bad_step++;
      tick(1);
    end
    chk("R9 address steps once per clock", bad_step, 0);

    // R5: early rise then re-fall restarts the pulse
    rst_n_in = 1'b0;
    tick(5);
    rst_n_in = 1'b1;
    tick(3);
    chk("R5 phy still low after early rise", {31'd0, phy_rst_n}, 0);
    rst_n_in = 1'b0;
    tick(1);
    chk("R5 phy low on re-fall", {31'd0, phy_rst_n}, 0);
    tick(15);
    chk("R5 phy low at edge 16 of restart", {31'd0, phy_rst_n}, 0);
    tick(1);
    chk("R5 phy high at edge 17 of restart", {31'd0, phy_rst_n}, 1);

    // R11: reset during clearing
    release_to_edge0();
    tick(30);
    chk("R11 clearing in progress", {31'd0, init_busy}, 1);
    rst_n_in = 1'b0;
    tick(1);
    chk("R11 status cleared at first edge", {29'd0, lock_busy, init_busy, init_done}, 0);
    chk("R11 core low", {31'd0, core_rst_n}, 0);
    release_to_edge0();
    chk("R11 lockout restarts", {29'd0, lock_busy, init_busy, init_done}, 3'b100);
    tick(19);
    chk("R11 lockout at edge 19", {31'd0, lock_busy}, 1);
    tick(1);
    chk("R11 clearing restarts at address 0", {16'd0, init_busy, init_addr}, {16'd0, 1'b1, 15'd0});
    finish_run();
  end
endmodule